// File: doc/BRIEF.md
# Edge-Pulse Isolation Channel Codec

This block models one digital isolation channel as clocked logic. A transmit half watches a logic input and sends a one-cycle "set" pulse for every rising edge and a one-cycle "clear" pulse for every falling edge. While the input stays still, it resends the current level as a refresh pulse at a fixed interval, so the far side stays correct at DC. A receive half keeps the output level in a bistable register: a set pulse drives it high and a clear pulse drives it low.

Each half has its own power-good input, standing in for an undervoltage lockout. While the transmit half is unpowered, it sends nothing. When it powers up, it sends the level it samples at once. While the receive half is unpowered, the output is held low. A receive-side watchdog forces the output low when no pulse of either kind has arrived for a set number of cycles, which marks the transmitter as dead. Two parameters, REFRESH_CYCLES and WATCHDOG_CYCLES, express time as clock cycles. WATCHDOG_CYCLES must exceed REFRESH_CYCLES.

Top module: `edge_pulse_iso_channel`

## Requirements
- R1: A change of `din` driven between clock edges produces one pulse, visible after the second rising edge: on `link_set` for a 0-to-1 change and on `link_clr` for a 1-to-0 change.
- R2: `dout` takes the level carried by a pulse on the rising edge after that pulse. As a result, `dout` still shows the old level after the second edge that follows a `din` change and shows the new level after the third.
- R3: With both halves powered and `din` steady, refresh pulses on the wire that matches the level (`link_set` for 1, `link_clr` for 0) arrive exactly every REFRESH_CYCLES rising edges after the last pulse.
- R4: `link_set` and `link_clr` are never high in the same cycle, and each pulse lasts exactly one cycle.
- R5: When no pulse arrives, `dout` goes low on the WATCHDOG_CYCLES-th rising edge after the edge that took the last pulse. It is still high one edge earlier.
- R6: While `tx_pwr_ok` is low, neither `link_set` nor `link_clr` pulses, whatever `din` does.
- R7: While `rx_pwr_ok` is low, `dout` is low and ignores pulses. After `rx_pwr_ok` rises, `dout` matches a steady `din` within REFRESH_CYCLES+2 rising edges.
- R8: On the first rising edge with `tx_pwr_ok` high after it was low, the transmitter sends a pulse for the sampled level of `din`, with no `din` edge needed.
- R9: During synchronous reset (`rst_n` low), `dout`, `link_set` and `link_clr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pwr_ok | input | 1 | Transmit-side supply above lockout |
| rx_pwr_ok | input | 1 | Receive-side supply above lockout |
| din | input | 1 | Logic input to be carried across |
| link_set | output | 1 | One-cycle pulse meaning "level is 1" |
| link_clr | output | 1 | One-cycle pulse meaning "level is 0" |
| dout | output | 1 | Rebuilt logic level |

## Verification
A refresh timer stuck or wrongly reloaded shows as refresh pulses that are missing or spaced wrongly. It appears within one REFRESH_CYCLES window of steady input. A wrong last-sent level shows as a lost or doubled edge pulse two edges after a `din` change, and `dout` is wrong on the following edge. A watchdog count that is off by one moves the forced-low edge of `dout` by one cycle, so the bench samples on both sides of that exact edge. A bad lockout term shows as pulses while the transmitter is off, or a high `dout` while the receiver is off.

// File: rtl/iso_chan_pkg.sv
// Package: shared types for the edge-pulse isolation channel.
// Assumes: one pulse carries one bit of level information.
package iso_chan_pkg;

    // The pair of pulse wires crossing the barrier
    typedef struct packed {
        logic set;
        logic clr;
    } iso_pulse_t;

endpackage

// File: rtl/iso_cycle_timer.sv
// Module: iso_cycle_timer
// Counts enabled cycles from zero up to LIMIT-1 and then holds there.
// done is high while the count sits at LIMIT-1. A clear restarts from zero.
// Assumes: LIMIT >= 2.
module iso_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count up to LAST and saturate, restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/iso_edge_tx.sv
// Module: iso_edge_tx
// Transmit half. It samples din into a register and compares it with the
// last level it sent. Any difference fires an edge pulse. A steady level is
// resent every REFRESH_CYCLES edges, and power-up sends the sampled level
// at once. Pulses are registered and one cycle wide.
// Assumes: REFRESH_CYCLES >= 2; din can be asynchronous to clk only if it is
// synchronised outside.
module iso_edge_tx
    import iso_chan_pkg::*;
#(
    parameter int REFRESH_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       din,
    output iso_pulse_t pulse
);
    logic din_q;
    logic last_q;
    logic up_q;
    logic fire;
    logic fire_lvl;
    logic refresh_due;
    iso_pulse_t pulse_q;

    // Purpose: sample the input every cycle, whatever the power state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= 1'b0;
        end else begin
            din_q <= din;
        end
    end

    // Purpose: choose whether a pulse goes out this cycle and its level
    always_comb begin
        fire     = 1'b0;
        fire_lvl = din_q;
        if (pwr_ok) begin
            if (!up_q) begin
                fire = 1'b1;
            end else if (din_q != last_q) begin
                fire = 1'b1;
            end else if (refresh_due) begin
                fire     = 1'b1;
                fire_lvl = last_q;
            end
        end
    end

    // Purpose: register the pulses and track the power-up and last-sent state
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            up_q    <= 1'b0;
            last_q  <= 1'b0;
            pulse_q <= '0;
        end else begin
            up_q        <= 1'b1;
            pulse_q.set <= fire && fire_lvl;
            pulse_q.clr <= fire && !fire_lvl;
            if (fire) begin
                last_q <= fire_lvl;
            end
        end
    end

    iso_cycle_timer #(.LIMIT(REFRESH_CYCLES)) u_refresh (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fire || !pwr_ok),
        .en   (1'b1),
        .done (refresh_due)
    );

    assign pulse = pulse_q;

endmodule

// File: rtl/iso_latch_rx.sv
// Module: iso_latch_rx
// Receive half. A bistable output register is set by a set pulse and
// cleared by a clear pulse. A watchdog restarted by every pulse forces the
// output low once WATCHDOG_CYCLES edges pass with no pulse.
// Assumes: set and clr never arrive together; if they do, set wins.
module iso_latch_rx
    import iso_chan_pkg::*;
#(
    parameter int WATCHDOG_CYCLES = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  iso_pulse_t pulse,
    output logic       dout
);
    logic starved;
    logic level_q;
    logic any_pulse;

    assign any_pulse = pulse.set || pulse.clr;

    // Purpose: hold the rebuilt level, drop it on lockout or starvation
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            level_q <= 1'b0;
        end else if (pulse.set) begin
            level_q <= 1'b1;
        end else if (pulse.clr) begin
            level_q <= 1'b0;
        end else if (starved) begin
            level_q <= 1'b0;
        end
    end

    iso_cycle_timer #(.LIMIT(WATCHDOG_CYCLES)) u_watchdog (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (any_pulse || !pwr_ok),
        .en   (1'b1),
        .done (starved)
    );

    assign dout = level_q;

endmodule

// File: rtl/edge_pulse_iso_channel.sv
// Module: edge_pulse_iso_channel
// Top level. It joins the transmit half and the receive half through the
// pulse pair, which is also brought out to ports.
// Assumes: WATCHDOG_CYCLES > REFRESH_CYCLES >= 2.
module edge_pulse_iso_channel #(
    parameter int REFRESH_CYCLES  = 16,
    parameter int WATCHDOG_CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_pwr_ok,
    input  logic rx_pwr_ok,
    input  logic din,
    output logic link_set,
    output logic link_clr,
    output logic dout
);
    import iso_chan_pkg::*;

    iso_pulse_t link;

    iso_edge_tx #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_ok(tx_pwr_ok),
        .din   (din),
        .pulse (link)
    );

    iso_latch_rx #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .pwr_ok(rx_pwr_ok),
        .pulse (link),
        .dout  (dout)
    );

    assign link_set = link.set;
    assign link_clr = link.clr;

endmodule

// File: rtl/iso_chan_chk.sv
// Module: iso_chan_chk
// Checker bound to the channel top. It watches the ports and keeps its own
// count of idle cycles on the pulse pair for the watchdog property.
module iso_chan_chk #(
    parameter int WATCHDOG_CYCLES = 80
) (
    input logic clk,
    input logic rst_n,
    input logic tx_pwr_ok,
    input logic rx_pwr_ok,
    input logic link_set,
    input logic link_clr,
    input logic dout
);
    localparam int IW = $clog2(WATCHDOG_CYCLES + 1);
    localparam logic [IW-1:0] IMAX = IW'(WATCHDOG_CYCLES);

    logic [IW-1:0] idle_q;

    // Purpose: count edges since the last pulse seen on either wire
    always_ff @(posedge clk) begin
        if (!rst_n || link_set || link_clr) begin
            idle_q <= '0;
        end else if (idle_q != IMAX) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R4
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_set && link_clr));

    // R4
    set_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_set |=> !link_set);

    // R4
    clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_clr |=> !link_clr);

    // R6
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pwr_ok |=> !(link_set || link_clr));

    // R7
    rx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pwr_ok |=> !dout);

    // R2
    set_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pwr_ok && link_set) |=> dout);

    // R2
    clr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_clr |=> !dout);

    // R5
    starve_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q == IMAX) |-> !dout);

endmodule

bind edge_pulse_iso_channel iso_chan_chk #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_pwr_ok(tx_pwr_ok),
    .rx_pwr_ok(rx_pwr_ok),
    .link_set (link_set),
    .link_clr (link_clr),
    .dout     (dout)
);

// File: tb/edge_pulse_iso_channel_bench.sv
module edge_pulse_iso_channel_bench;
    localparam int RC = 16;
    localparam int WC = 80;
    localparam int NV = 8;
    // {din level, extra hold cycles}
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 8'd3}, {1'b1, 8'd0}, {1'b0, 8'd5}, {1'b1, 8'd1},
        {1'b0, 8'd20}, {1'b1, 8'd2}, {1'b0, 8'd0}, {1'b1, 8'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_pwr_ok = 1'b0;
    logic rx_pwr_ok = 1'b0;
    logic din = 1'b0;
    logic link_set, link_clr, dout;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_pulse_iso_channel #(.REFRESH_CYCLES(RC), .WATCHDOG_CYCLES(WC)) u_edge_pulse_iso_channel (
        .clk(clk), .rst_n(rst_n), .tx_pwr_ok(tx_pwr_ok), .rx_pwr_ok(rx_pwr_ok),
        .din(din), .link_set(link_set), .link_clr(link_clr), .dout(dout)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        int gap;
        logic prev;
        @(negedge clk);
        din = 1'b1;
        repeat (3) step();
        // R9 reset state
        check("R9 dout in reset", dout, 1'b0);
        check("R9 set in reset", link_set, 1'b0);
        check("R9 clr in reset", link_clr, 1'b0);
        rst_n = 1'b1;
        step();
        rx_pwr_ok = 1'b1;
        tx_pwr_ok = 1'b1;
        step();
        // R8 power-up pulse with no din edge
        check("R8 power-up set", link_set, 1'b1);
        step();
        check("R8 dout after power-up", dout, 1'b1);

        // R1 R2 vector walk
        prev = 1'b1;
        for (int i = 0; i < NV; i++) begin
            din = VEC[i][8];
            step();
            step();
            check("R1 set pulse", link_set, VEC[i][8] && !prev);
            check("R1 clr pulse", link_clr, !VEC[i][8] && prev);
            check("R2 dout still old", dout, prev);
            step();
            check("R2 dout new", dout, VEC[i][8]);
            for (int h = 0; h < int'(VEC[i][7:0]); h++) step();
            check("R2 dout held", dout, VEC[i][8]);
            prev = VEC[i][8];
        end

        // R3 refresh spacing with steady level 0
        din = 1'b0;
        step();
        step();
        check("R1 clr before refresh", link_clr, 1'b1);
        cnt = 0;
        gap = 0;
        for (int c = 1; c <= 4 * RC; c++) begin
            step();
            if (link_clr) begin
                cnt++;
                if (gap == 0) gap = c;
            end
            if (link_set) cnt += 100;
            if (link_set && link_clr) cnt += 1000; // R4
        end
        check_int("R3 refresh count", cnt, 4);
        check_int("R3 refresh spacing", gap, RC);
        check("R3 level held low", dout, 1'b0);

        // R5 R6 watchdog after transmitter loss
        din = 1'b1;
        step();
        step();
        check("R1 set before loss", link_set, 1'b1);
        tx_pwr_ok = 1'b0;
        step();
        check("R5 dout high at start", dout, 1'b1);
        cnt = 0;
        for (int c = 0; c < WC - 1; c++) begin
            din = c[2];
            step();
            if (link_set || link_clr) cnt++;
        end
        check_int("R6 no pulses while tx off", cnt, 0);
        check("R5 dout high one edge before", dout, 1'b1);
        step();
        check("R5 dout forced low", dout, 1'b0);

        // R8 transmitter returns
        din = 1'b1;
        tx_pwr_ok = 1'b1;
        step();
        check("R8 set on return", link_set, 1'b1);
        step();
        check("R8 dout restored", dout, 1'b1);

        // R7 receiver lockout
        rx_pwr_ok = 1'b0;
        step();
        check("R7 dout low in lockout", dout, 1'b0);
        din = 1'b0;
        repeat (3) step();
        din = 1'b1;
        step();
        step();
        check("R7 set pulse reaches rx", link_set, 1'b1);
        step();
        check("R7 pulse ignored", dout, 1'b0);
        rx_pwr_ok = 1'b1;
        repeat (RC + 2) step();
        check("R7 dout recovers", dout, 1'b1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule